// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides when a peripheral's bus and core may run. It has four power states: inactive, powerdown, powered up and partial powerdown. The active-low reset input moves the block between them, and so do writes to two bits of a control register. One bit requests operation and the other requests shutdown. When the control register is read back, these two bits show the current power state, not the last value written. The block also holds a small register file. Its contents survive powerdown for as long as reset stays high.

The first clock after reset is released moves the block from inactive to powerdown. On that same clock the block samples two pin pairs and decides which host-bus mode applies. That mode then stays fixed until the next reset. Before a powerup is allowed, two things are checked: a supplies-and-clock-ready input, and a field in a decoder-configuration register. A refused powerup sets a sticky error flag. Register access uses a valid/ready request channel and a valid/ready read-response channel. The block accepts no new request while a read response is waiting. A response is held, with its data unchanged, until the host takes it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is inactive (00) and `bus_en`, `core_en` and `req_ready` are 0. All registers return to zero, so after reset the scratch register reads 0.
- R2: The first clock after `rst_n` rises moves the state to powerdown (01) and latches `bus_mode` from the pins. The rules are checked in this order: `pin_sen`=1 with `pin_sdio`=0 gives 00; otherwise `pin_gp3`=1 with `pin_gp1`=0 gives 01; any other combination gives 10, a reserved code. The value does not change until the next reset.
- R3: In powerdown, a write to the control register (address 0) with bit 0 = 1 and bit 1 = 0 is a powerup request. It moves the block to powered up (10) at the accepting edge, and `core_en` goes to 1, but only when `supply_ok` is 1 and bits [3:0] of the decoder register (address 1) are zero.
- R4: A powerup request that fails either condition leaves the block in powerdown and sets a sticky error flag. The flag is bit 2 of the status register (address 2). A read of the status register returns the flag and clears it.
- R5: In powered up, a control write with bit 0 = 1 and bit 1 = 1 enters partial powerdown (11). The block stays there for exactly 4 cycles and then returns to powerdown.
- R6: All register writes accepted during partial powerdown are ignored.
- R7: A control write with bit 0 = 0 moves powered up to powerdown, and leaves powerdown in powerdown, whatever bit 1 holds.
- R8: A control read returns bit 0/bit 1 as 0/0 in powerdown, 1/0 in powered up, and 0/1 in partial powerdown. Bits 15:2 return the last value written to them.
- R9: Register contents, such as the scratch register at address 3, are kept through powerdown and powerup.
- R10: A request is taken when `req_valid` and `req_ready` are both high. A read response appears on the next cycle. `req_ready` stays low while a response is pending. `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is high.
- R11: The status register holds `bus_mode` in bits [1:0] and the power state in bits [4:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; low means inactive |
| pin_sen | input | 1 | First pin pair, select-enable pin |
| pin_sdio | input | 1 | First pin pair, data pin |
| pin_gp1 | input | 1 | Second pin pair, general-purpose pin 1 |
| pin_gp3 | input | 1 | Second pin pair, general-purpose pin 3 |
| supply_ok | input | 1 | Supplies and reference clock present |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 16 | Read data |
| bus_mode | output | 2 | Latched bus mode |
| bus_en | output | 1 | Bus interface enabled |
| core_en | output | 1 | Core enabled (powered up) |
| pwr_state | output | 2 | Current power state |

## Verification
The partial powerdown window is the hardest situation to reach from the ports. The block must first be powered up with both guards satisfied. A shutdown write must then be followed, within four cycles, by a write and a read. The bench issues these back to back, right after the accepting edge. That way the stray scratch write lands inside the window, and a control read inside the window shows the 0/1 readback. The bench then repeats the entry and checks the state on each of the following cycles, to confirm the exact four-cycle length.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PS_INACT = 2'b00,
    PS_DOWN  = 2'b01,
    PS_UP    = 2'b10,
    PS_PART  = 2'b11
  } pwr_state_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DEC  = 1;
  localparam int unsigned ADDR_STAT = 2;
  localparam int unsigned ADDR_SCR0 = 3;

  localparam logic [1:0] MODE_PAIR_A = 2'b00;
  localparam logic [1:0] MODE_PAIR_B = 2'b01;
  localparam logic [1:0] MODE_RSVD   = 2'b10;
endpackage

// File: rtl/pwr_mode_latch.sv
module pwr_mode_latch
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       pin_sen,
  input  logic       pin_sdio,
  input  logic       pin_gp1,
  input  logic       pin_gp3,
  output logic [1:0] mode
);
  logic [1:0] mode_next;

  always_comb begin
    if (pin_sen && !pin_sdio)      mode_next = MODE_PAIR_A;
    else if (pin_gp3 && !pin_gp1)  mode_next = MODE_PAIR_B;
    else                           mode_next = MODE_RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= MODE_PAIR_A;
    else if (capture) mode <= mode_next;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned PART_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       wr_enable,
  input  logic       wr_disable,
  input  logic       dec_zero,
  input  logic       supply_ok,
  input  logic       stat_rd,
  output pwr_state_e state,
  output logic       err,
  output logic       capture
);
  localparam int unsigned CW = (PART_CYC > 1) ? $clog2(PART_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(PART_CYC - 1);

  pwr_state_e    state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          err_set;

  assign capture = (state == PS_INACT);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    err_set = 1'b0;
    unique case (state)
      PS_INACT: state_n = PS_DOWN;
      PS_DOWN: begin
        if (ctrl_wr && wr_enable && !wr_disable) begin
          if (supply_ok && dec_zero) state_n = PS_UP;
          else                       err_set = 1'b1;
        end
      end
      PS_UP: begin
        if (ctrl_wr) begin
          if (!wr_enable) state_n = PS_DOWN;
          else if (wr_disable) begin
            state_n = PS_PART;
            cnt_n   = CNT_LOAD;
          end
        end
      end
      PS_PART: begin
        if (cnt == '0) state_n = PS_DOWN;
        else           cnt_n   = cnt - 1'b1;
      end
      default: state_n = PS_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_INACT;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (err_set)      err <= 1'b1;
      else if (stat_rd) err <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 2,
  parameter int unsigned DEC_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  pwr_state_e    state,
  input  logic [1:0]    mode,
  input  logic          err,
  output logic          dec_zero,
  output logic [DW-1:0] rdata
);
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned NSCR = NREG - ADDR_SCR0;

  logic [DW-1:2] ctrl_hi;
  logic [DW-1:0] dec_q;
  logic [DW-1:0] scr_q [NSCR];
  logic          en_rb, dis_rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hi <= '0;
      dec_q   <= '0;
    end else if (wr_en) begin
      if (addr == AW'(ADDR_CTRL)) ctrl_hi <= wdata[DW-1:2];
      if (addr == AW'(ADDR_DEC))  dec_q   <= wdata;
    end
  end

  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scr_q[g] <= '0;
      else if (wr_en && addr == AW'(ADDR_SCR0 + g)) scr_q[g] <= wdata;
    end
  end

  assign dec_zero = (dec_q[DEC_W-1:0] == '0);

  always_comb begin
    en_rb  = (state == PS_UP);
    dis_rb = (state == PS_PART);
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL))      rdata = {ctrl_hi, dis_rb, en_rb};
    else if (addr == AW'(ADDR_DEC))  rdata = dec_q;
    else if (addr == AW'(ADDR_STAT)) rdata[4:0] = {state, err, mode};
    else begin
      for (int i = 0; i < NSCR; i++)
        if (addr == AW'(ADDR_SCR0 + i)) rdata = scr_q[i];
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 2,
  parameter int unsigned DEC_W    = 4,
  parameter int unsigned PART_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_sen,
  input  logic          pin_sdio,
  input  logic          pin_gp1,
  input  logic          pin_gp3,
  input  logic          supply_ok,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    bus_mode,
  output logic          bus_en,
  output logic          core_en,
  output logic [1:0]    pwr_state
);
  pwr_state_e    state;
  logic          err, capture, dec_zero;
  logic          acc, wr_ok, ctrl_wr, stat_rd;
  logic [DW-1:0] rdata;

  assign bus_en    = (state != PS_INACT);
  assign core_en   = (state == PS_UP);
  assign pwr_state = state;
  assign req_ready = bus_en && !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign wr_ok     = acc && req_write && (state != PS_PART);
  assign ctrl_wr   = wr_ok && (req_addr == AW'(ADDR_CTRL));
  assign stat_rd   = acc && !req_write && (req_addr == AW'(ADDR_STAT));

  pwr_mode_latch u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .pin_sen(pin_sen), .pin_sdio(pin_sdio), .pin_gp1(pin_gp1), .pin_gp3(pin_gp3),
    .mode(bus_mode)
  );

  pwr_fsm #(.PART_CYC(PART_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wr_enable(req_wdata[0]), .wr_disable(req_wdata[1]),
    .dec_zero(dec_zero), .supply_ok(supply_ok), .stat_rd(stat_rd),
    .state(state), .err(err), .capture(capture)
  );

  pwr_regfile #(.DW(DW), .AW(AW), .DEC_W(DEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(req_addr), .wdata(req_wdata),
    .state(state), .mode(bus_mode), .err(err), .dec_zero(dec_zero), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [1:0]    bus_mode,
  input logic          bus_en,
  input logic          core_en,
  input logic [1:0]    pwr_state
);
  AST_INACT_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b00 |-> !bus_en && !req_ready && !core_en); // R1
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b00 |=> $stable(bus_mode)); // R2
  AST_UP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> $past(supply_ok)); // R3
  AST_UP_FROM_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && $past(pwr_state) != 2'b10) |-> $past(pwr_state) == 2'b01); // R3
  AST_PART_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b11 |=> pwr_state == 2'b11 || pwr_state == 2'b01); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .bus_mode(bus_mode), .bus_en(bus_en), .core_en(core_en), .pwr_state(pwr_state)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_sen = 1'b1, pin_sdio = 1'b0, pin_gp1 = 1'b0, pin_gp3 = 1'b0;
  logic        supply_ok = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_en, core_en;
  logic [15:0] rsp_data;
  logic [1:0]  bus_mode, pwr_state;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_sen(pin_sen), .pin_sdio(pin_sdio),
    .pin_gp1(pin_gp1), .pin_gp3(pin_gp3), .supply_ok(supply_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .bus_mode(bus_mode),
    .bus_en(bus_en), .core_en(core_en), .pwr_state(pwr_state)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data when a response is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", rsp_data, 16'hxxxx);
      else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 state in reset", 16'(pwr_state), 16'h0);
    chk("R1 bus/core/ready off", {13'd0, bus_en, core_en, req_ready}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R2 powerdown after release", 16'(pwr_state), 16'h1);
    chk("R2 mode pair A", 16'(bus_mode), 16'h0);
    pin_sen = 1'b0; pin_gp3 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 mode held after pin change", 16'(bus_mode), 16'h0);

    rd(2'd0, 16'h0000, "R8 ctrl readback powerdown");
    wr(2'd3, 16'hBEEF);
    rd(2'd3, 16'hBEEF, "R9 scratch write");

    // refused: no supply
    wr(2'd0, 16'h0001);
    chk("R4 stays powerdown without supply", 16'(pwr_state), 16'h1);
    rd(2'd2, 16'h000C, "R4 R11 status err set");
    rd(2'd2, 16'h0008, "R4 status err cleared");

    // refused: decoder field non-zero
    supply_ok = 1'b1;
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0001);
    chk("R4 stays powerdown with decoder field", 16'(pwr_state), 16'h1);
    rd(2'd2, 16'h000C, "R4 status err decoder");

    // accepted
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h0101);
    chk("R3 powered up", 16'(pwr_state), 16'h2);
    chk("R3 core_en", 16'(core_en), 16'h1);
    rd(2'd0, 16'h0101, "R8 ctrl readback powered up");
    rd(2'd3, 16'hBEEF, "R9 scratch kept through powerup");
    rd(2'd2, 16'h0010, "R11 status powered up");

    // partial powerdown with stray write and read inside window
    wr(2'd0, 16'h0103);
    chk("R5 partial entered", 16'(pwr_state), 16'h3);
    wr(2'd3, 16'h1234);
    rd(2'd0, 16'h0102, "R8 ctrl readback partial");
    drain();
    repeat (4) @(negedge clk);
    chk("R5 back in powerdown", 16'(pwr_state), 16'h1);
    rd(2'd3, 16'hBEEF, "R6 write in partial ignored");

    // exact window length
    wr(2'd0, 16'h0001);
    chk("R3 powered up again", 16'(pwr_state), 16'h2);
    wr(2'd0, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      chk("R5 partial cycle", 16'(pwr_state), 16'h3);
      @(negedge clk);
    end
    chk("R5 powerdown after 4 cycles", 16'(pwr_state), 16'h1);

    // ENABLE=0 paths
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0002);
    chk("R7 enable=0 leaves powered up", 16'(pwr_state), 16'h1);
    chk("R7 core off", 16'(core_en), 16'h0);
    wr(2'd0, 16'h0000);
    chk("R7 enable=0 keeps powerdown", 16'(pwr_state), 16'h1);
    rd(2'd0, 16'h0000, "R8 ctrl readback after shutdown");
    drain();

    // back-pressure
    rsp_ready = 1'b0;
    rd(2'd3, 16'hBEEF, "R10 held response");
    chk("R10 response valid", 16'(rsp_valid), 16'h1);
    chk("R10 ready low while pending", 16'(req_ready), 16'h0);
    repeat (3) @(negedge clk);
    chk("R10 response still valid", 16'(rsp_valid), 16'h1);
    chk("R10 data stable", rsp_data, 16'hBEEF);
    rsp_ready = 1'b1;
    drain();
    chk("R10 response released", 16'(rsp_valid), 16'h0);

    // second reset, pair B, defaults
    pin_sen = 1'b0; pin_gp3 = 1'b1; pin_gp1 = 1'b0;
    do_reset();
    chk("R2 mode pair B", 16'(bus_mode), 16'h1);
    rd(2'd3, 16'h0000, "R1 scratch default after reset");
    drain();

    // third reset, reserved
    pin_gp3 = 1'b0;
    do_reset();
    chk("R2 mode reserved", 16'(bus_mode), 16'h2);
    rd(2'd2, 16'h000A, "R11 status reserved mode");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule